// File: doc/BRIEF.md
# CCD Sensor Drive Timing Generator

This block is the timing generator for an interline progressive-scan CCD. It runs from one master pixel clock and produces the logic-level drive signals:
- horizontal and vertical sync;
- a four-phase vertical transfer pattern;
- two sensor readout gate pulses;
- complementary horizontal transfer clocks;
- a reset gate pulse;
- an electronic-shutter substrate pulse.

External level shifters and vertical drivers turn these into sensor voltages. A pixel counter and a line counter set the position in the frame, and every output is a function of that position, the latched scan mode and the latched shutter setting.

There are two scan modes. Progressive scan (`mode_fast` = 0) uses every line, has a frame of `PROG_LINES` lines, and fires both readout gates. Fast scan (`mode_fast` = 1) has a frame of `HFR_LINES` lines. It moves four row packets per line, so each output line combines a group of sensor rows, and it fires only the first gate. A shutter setting `S` chooses the last line that gets a substrate drain pulse before the readout line, which is line 1. `S` = 0 turns the shutter off, so exposure spans a full frame.

Two state machines make the vertical signals. The transfer machine has the states VT_IDLE, VT_S1, VT_S2 and VT_S3:
- VT_IDLE to VT_S1 at pixel `VT_START` of a line other than line 1;
- VT_S1 to VT_S2 and VT_S2 to VT_S3 after `VSTEP` clocks each;
- VT_S3 back to VT_S1 when more packets remain, or to VT_IDLE after the last packet.

The readout machine has the states RO_IDLE, RO_LEAD, RO_GATE and RO_TRAIL:
- RO_IDLE to RO_LEAD at pixel `SG_START` of line 1;
- RO_LEAD to RO_GATE after `SG_GUARD` clocks;
- RO_GATE to RO_TRAIL after `SG_CLKS` clocks;
- RO_TRAIL back to RO_IDLE after `SG_GUARD` clocks.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst` is high, the outputs hold their rest values: hd_n=1, vd_n=1, vphase=4'b0110, xsg1_n=1, xsg2_n=1, h1=1, h2=0, rg=0 and sub_n=1. The position counters restart at pixel 0 of line 1. Every output is registered, so in clock cycle n+1 (counted from reset release, cycle 0 being the first cycle with rst low) it shows the value for position n.
- R2: A line lasts `LINE_CLKS` clocks (pixels 0 to LINE_CLKS-1). hd_n is low for pixels 0 to HD_CLKS-1 and high for the rest of the line.
- R3: A frame has `PROG_LINES` lines when mode is 0 and `HFR_LINES` lines when mode is 1. vd_n is low for all pixels of line 1 and high on every other line.
- R4: `mode_fast` and `shutter_lines` are sampled only during reset and on the last pixel of the last line of a frame. Changing them at any other time does not change the frame in progress.
- R5: On every line except line 1, vphase (bit order {V3,V2B,V2A,V1}) steps through packets starting at pixel `VT_START`. Each packet is 4'b1100, then 4'b1001, then 4'b0011, each held for `VSTEP` clocks. There is one packet per line in mode 0 and four back-to-back packets in mode 1. At all other times vphase is 4'b0110.
- R6: On line 1, xsg1_n is low for pixels SG_START+SG_GUARD up to, but not including, SG_START+SG_GUARD+SG_CLKS. vphase holds 4'b0110 for the whole of line 1.
- R7: In mode 0, xsg2_n follows xsg1_n exactly. In mode 1, xsg2_n stays high.
- R8: From pixel `HACT_START` to the end of the line, h1 is 1 on even pixels and 0 on odd pixels. Before `HACT_START`, h1 is 1. h2 is always the inverse of h1.
- R9: rg is 1 on odd pixels at or after `HACT_START` and 0 everywhere else.
- R10: When S is not 0, sub_n is low for pixels SUB_START up to SUB_START+SUB_CLKS-1 on each line L with 2 <= L and L+S <= frame length. On all other lines it is high.
- R11: With S = 0, sub_n stays high for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_fast | input | 1 | 0 = progressive scan, 1 = fast line-skipping scan |
| shutter_lines | input | LINE_W | Shutter setting S, in lines before readout |
| hd_n | output | 1 | Horizontal sync, active low |
| vd_n | output | 1 | Vertical sync, active low |
| vphase | output | 4 | Vertical transfer phases {V3,V2B,V2A,V1}, 1 = phase high |
| xsg1_n | output | 1 | Readout gate for the V2A field, active low |
| xsg2_n | output | 1 | Readout gate for the V2B field, active low |
| h1 | output | 1 | Horizontal transfer clock |
| h2 | output | 1 | Horizontal transfer clock, complement of h1 |
| rg | output | 1 | Reset gate pulse, active high |
| sub_n | output | 1 | Substrate drain pulse, active low |

## Verification
The bench walks a table of mode and shutter settings, with run lengths chosen so that most changes arrive in the middle of a frame. Every output is compared each cycle against a position model built from the requirements. Alternating the modes tells the two frame lengths, the two packet counts and the single-gate versus dual-gate readout apart. It also shows that a mid-frame change waits for the frame boundary. The shutter values in the table are 0, small values, and a value that leaves no line eligible for a pulse, which separates the no-shutter case from the edge of the eligible window. Directed runs check the reset values, measure one frame length in each mode, and count substrate pulse cycles over a whole frame.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [1:0] {
        VT_IDLE,
        VT_S1,
        VT_S2,
        VT_S3
    } vt_state_t;

    typedef enum logic [1:0] {
        RO_IDLE,
        RO_LEAD,
        RO_GATE,
        RO_TRAIL
    } ro_state_t;

    // vertical phase patterns, bit order {V3,V2B,V2A,V1}
    localparam logic [3:0] VP_REST  = 4'b0110;
    localparam logic [3:0] VP_STEP1 = 4'b1100;
    localparam logic [3:0] VP_STEP2 = 4'b1001;
    localparam logic [3:0] VP_STEP3 = 4'b0011;

    localparam int FAST_PACKETS = 4;

endpackage

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
    parameter int LINE_CLKS  = 1790,
    parameter int PROG_LINES = 1068,
    parameter int HFR_LINES  = 267,
    parameter int PW         = $clog2(LINE_CLKS),
    parameter int LW         = $clog2(PROG_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_in,
    input  logic [LW-1:0] shut_in,
    output logic [PW-1:0] pix,
    output logic [LW-1:0] line,
    output logic [LW-1:0] frame_last,
    output logic          mode_q,
    output logic [LW-1:0] shut_q
);

    localparam logic [PW-1:0] PIX_LAST  = PW'(LINE_CLKS - 1);
    localparam logic [LW-1:0] PROG_LAST = LW'(PROG_LINES);
    localparam logic [LW-1:0] FAST_LAST = LW'(HFR_LINES);

    logic frame_wrap;

    assign frame_last = mode_q ? FAST_LAST : PROG_LAST;
    assign frame_wrap = (pix == PIX_LAST) && (line == frame_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix    <= '0;
            line   <= LW'(1);
            mode_q <= mode_in;
            shut_q <= shut_in;
        end else if (pix == PIX_LAST) begin
            pix <= '0;
            if (line == frame_last) begin
                line   <= LW'(1);
                mode_q <= mode_in;
                shut_q <= shut_in;
            end else begin
                line <= line + 1'b1;
            end
        end else begin
            pix <= pix + 1'b1;
        end
    end

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_wrap)) |-> ($stable(mode_q) && $stable(shut_q)));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        (line != '0) && (line <= frame_last));

endmodule

// File: rtl/ccd_vert_seq.sv
module ccd_vert_seq
    import ccd_tg_pkg::*;
#(
    parameter int PW       = 11,
    parameter int LW       = 11,
    parameter int VT_START = 96,
    parameter int VSTEP    = 16,
    parameter int SG_START = 96,
    parameter int SG_GUARD = 50,
    parameter int SG_CLKS  = 800
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic          mode_fast,
    output logic [3:0]    vphase,
    output logic          xsg1_n,
    output logic          xsg2_n
);

    localparam int VCW = $clog2(VSTEP) + 1;
    localparam int RMAX = (SG_CLKS > SG_GUARD) ? SG_CLKS : SG_GUARD;
    localparam int RCW = $clog2(RMAX) + 1;

    localparam logic [PW-1:0]  VT_P      = PW'(VT_START);
    localparam logic [PW-1:0]  SG_P      = PW'(SG_START);
    localparam logic [VCW-1:0] STEP_LAST = VCW'(VSTEP - 1);
    localparam logic [RCW-1:0] GRD_LAST  = RCW'(SG_GUARD - 1);
    localparam logic [RCW-1:0] GATE_LAST = RCW'(SG_CLKS - 1);

    vt_state_t      vt_st, vt_nxt;
    ro_state_t      ro_st, ro_nxt;
    logic [VCW-1:0] vt_cnt, vt_cnt_nxt;
    logic [1:0]     pkt_cnt, pkt_nxt, pkt_last;
    logic [RCW-1:0] ro_cnt, ro_cnt_nxt;
    logic           on_rd_line;

    assign on_rd_line = (line == LW'(1));
    assign pkt_last   = mode_fast ? 2'(FAST_PACKETS - 1) : 2'd0;

    // transfer machine: next state
    always_comb begin
        vt_nxt     = vt_st;
        vt_cnt_nxt = vt_cnt + 1'b1;
        pkt_nxt    = pkt_cnt;
        unique case (vt_st)
            VT_IDLE: begin
                vt_cnt_nxt = '0;
                pkt_nxt    = '0;
                if (!on_rd_line && pix == VT_P) vt_nxt = VT_S1;
            end
            VT_S1: if (vt_cnt == STEP_LAST) begin
                vt_nxt     = VT_S2;
                vt_cnt_nxt = '0;
            end
            VT_S2: if (vt_cnt == STEP_LAST) begin
                vt_nxt     = VT_S3;
                vt_cnt_nxt = '0;
            end
            VT_S3: if (vt_cnt == STEP_LAST) begin
                vt_cnt_nxt = '0;
                if (pkt_cnt == pkt_last) begin
                    vt_nxt  = VT_IDLE;
                    pkt_nxt = '0;
                end else begin
                    vt_nxt  = VT_S1;
                    pkt_nxt = pkt_cnt + 1'b1;
                end
            end
            default: vt_nxt = VT_IDLE;
        endcase
    end

    // readout machine: next state
    always_comb begin
        ro_nxt     = ro_st;
        ro_cnt_nxt = ro_cnt + 1'b1;
        unique case (ro_st)
            RO_IDLE: begin
                ro_cnt_nxt = '0;
                if (on_rd_line && pix == SG_P) ro_nxt = RO_LEAD;
            end
            RO_LEAD: if (ro_cnt == GRD_LAST) begin
                ro_nxt     = RO_GATE;
                ro_cnt_nxt = '0;
            end
            RO_GATE: if (ro_cnt == GATE_LAST) begin
                ro_nxt     = RO_TRAIL;
                ro_cnt_nxt = '0;
            end
            RO_TRAIL: if (ro_cnt == GRD_LAST) begin
                ro_nxt     = RO_IDLE;
                ro_cnt_nxt = '0;
            end
            default: ro_nxt = RO_IDLE;
        endcase
    end

    // state registers
    always_ff @(posedge clk) begin
        if (rst) begin
            vt_st   <= VT_IDLE;
            vt_cnt  <= '0;
            pkt_cnt <= '0;
            ro_st   <= RO_IDLE;
            ro_cnt  <= '0;
        end else begin
            vt_st   <= vt_nxt;
            vt_cnt  <= vt_cnt_nxt;
            pkt_cnt <= pkt_nxt;
            ro_st   <= ro_nxt;
            ro_cnt  <= ro_cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        unique case (vt_st)
            VT_S1:   vphase = VP_STEP1;
            VT_S2:   vphase = VP_STEP2;
            VT_S3:   vphase = VP_STEP3;
            default: vphase = VP_REST;
        endcase
        xsg1_n = !(ro_st == RO_GATE);
        xsg2_n = !((ro_st == RO_GATE) && !mode_fast);
    end

    // R5
    vphase_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(vphase) == 2);

    // R7
    xsg_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !xsg2_n |-> !xsg1_n);

    // R6
    gate_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !xsg1_n |-> (vphase == VP_REST));

endmodule

// File: rtl/ccd_horiz_gen.sv
module ccd_horiz_gen #(
    parameter int PW         = 11,
    parameter int LW         = 11,
    parameter int HD_CLKS    = 64,
    parameter int HACT_START = 392,
    parameter int SUB_START  = 300,
    parameter int SUB_CLKS   = 56
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pix,
    input  logic [LW-1:0] line,
    input  logic [LW-1:0] frame_last,
    input  logic [LW-1:0] shut_q,
    output logic          hd_n,
    output logic          vd_n,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          sub_n
);

    localparam logic [PW-1:0] HD_P    = PW'(HD_CLKS);
    localparam logic [PW-1:0] HACT_P  = PW'(HACT_START);
    localparam logic [PW-1:0] SUB_P   = PW'(SUB_START);
    localparam logic [PW-1:0] SUB_E_P = PW'(SUB_START + SUB_CLKS);

    logic act, h1_d, sub_win, sub_line;

    assign act      = (pix >= HACT_P);
    assign h1_d     = act ? ~pix[0] : 1'b1;
    assign sub_win  = (pix >= SUB_P) && (pix < SUB_E_P);
    assign sub_line = (shut_q != '0) && (line >= LW'(2)) &&
                      (({1'b0, line} + {1'b0, shut_q}) <= {1'b0, frame_last});

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_n  <= 1'b1;
            vd_n  <= 1'b1;
            h1    <= 1'b1;
            h2    <= 1'b0;
            rg    <= 1'b0;
            sub_n <= 1'b1;
        end else begin
            hd_n  <= !(pix < HD_P);
            vd_n  <= !(line == LW'(1));
            h1    <= h1_d;
            h2    <= ~h1_d;
            rg    <= act & pix[0];
            sub_n <= !(sub_win && sub_line);
        end
    end

    // R8
    h_compl_chk: assert property (@(posedge clk) disable iff (rst)
        h1 != h2);

    // R10
    sub_line_chk: assert property (@(posedge clk) disable iff (rst)
        !sub_n |-> vd_n);

    // R9
    rg_phase_chk: assert property (@(posedge clk) disable iff (rst)
        rg |-> !h1);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
    parameter int LINE_CLKS  = 1790,
    parameter int HD_CLKS    = 64,
    parameter int HACT_START = 392,
    parameter int VT_START   = 96,
    parameter int VSTEP      = 16,
    parameter int SUB_START  = 300,
    parameter int SUB_CLKS   = 56,
    parameter int SG_START   = 96,
    parameter int SG_GUARD   = 50,
    parameter int SG_CLKS    = 800,
    parameter int PROG_LINES = 1068,
    parameter int HFR_LINES  = 267,
    parameter int LINE_W     = $clog2(PROG_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_fast,
    input  logic [LINE_W-1:0] shutter_lines,
    output logic              hd_n,
    output logic              vd_n,
    output logic [3:0]        vphase,
    output logic              xsg1_n,
    output logic              xsg2_n,
    output logic              h1,
    output logic              h2,
    output logic              rg,
    output logic              sub_n
);

    localparam int PW = $clog2(LINE_CLKS);

    logic [PW-1:0]     pix;
    logic [LINE_W-1:0] line;
    logic [LINE_W-1:0] frame_last;
    logic [LINE_W-1:0] shut_q;
    logic              mode_q;

    ccd_line_timer #(
        .LINE_CLKS (LINE_CLKS),
        .PROG_LINES(PROG_LINES),
        .HFR_LINES (HFR_LINES),
        .PW        (PW),
        .LW        (LINE_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .mode_in   (mode_fast),
        .shut_in   (shutter_lines),
        .pix       (pix),
        .line      (line),
        .frame_last(frame_last),
        .mode_q    (mode_q),
        .shut_q    (shut_q)
    );

    ccd_vert_seq #(
        .PW      (PW),
        .LW      (LINE_W),
        .VT_START(VT_START),
        .VSTEP   (VSTEP),
        .SG_START(SG_START),
        .SG_GUARD(SG_GUARD),
        .SG_CLKS (SG_CLKS)
    ) u_vert (
        .clk      (clk),
        .rst      (rst),
        .pix      (pix),
        .line     (line),
        .mode_fast(mode_q),
        .vphase   (vphase),
        .xsg1_n   (xsg1_n),
        .xsg2_n   (xsg2_n)
    );

    ccd_horiz_gen #(
        .PW        (PW),
        .LW        (LINE_W),
        .HD_CLKS   (HD_CLKS),
        .HACT_START(HACT_START),
        .SUB_START (SUB_START),
        .SUB_CLKS  (SUB_CLKS)
    ) u_horiz (
        .clk       (clk),
        .rst       (rst),
        .pix       (pix),
        .line      (line),
        .frame_last(frame_last),
        .shut_q    (shut_q),
        .hd_n      (hd_n),
        .vd_n      (vd_n),
        .h1        (h1),
        .h2        (h2),
        .rg        (rg),
        .sub_n     (sub_n)
    );

endmodule

// File: tb/sim_ccd_timing_gen.sv
`timescale 1ns/1ps
module sim_ccd_timing_gen;

    localparam int LC = 100, HDC = 8, HACT = 60, VTS = 10, VST = 2;
    localparam int SUBS = 40, SUBC = 6, SGS = 10, SGG = 5, SGC = 30;
    localparam int PL = 24, FL = 6, LW = $clog2(PL + 1);

    typedef struct packed {
        logic          mode;
        logic [LW-1:0] shut;
        logic [15:0]   cyc;
    } scen_t;

    localparam int NSC = 8;
    localparam scen_t SCEN [NSC] = '{
        '{1'b0, 5'd0,  16'd2600},
        '{1'b0, 5'd5,  16'd5000},
        '{1'b1, 5'd2,  16'd1500},
        '{1'b1, 5'd0,  16'd700},
        '{1'b0, 5'd23, 16'd2500},
        '{1'b1, 5'd3,  16'd1900},
        '{1'b0, 5'd1,  16'd3000},
        '{1'b1, 5'd5,  16'd1300}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_fast = 1'b0;
    logic [LW-1:0] shutter_lines = '0;
    logic          hd_n, vd_n, xsg1_n, xsg2_n, h1, h2, rg, sub_n;
    logic [3:0]    vphase;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ccd_timing_gen #(
        .LINE_CLKS(LC), .HD_CLKS(HDC), .HACT_START(HACT), .VT_START(VTS),
        .VSTEP(VST), .SUB_START(SUBS), .SUB_CLKS(SUBC), .SG_START(SGS),
        .SG_GUARD(SGG), .SG_CLKS(SGC), .PROG_LINES(PL), .HFR_LINES(FL)
    ) u0 (
        .clk(clk), .rst(rst), .mode_fast(mode_fast), .shutter_lines(shutter_lines),
        .hd_n(hd_n), .vd_n(vd_n), .vphase(vphase), .xsg1_n(xsg1_n), .xsg2_n(xsg2_n),
        .h1(h1), .h2(h2), .rg(rg), .sub_n(sub_n)
    );

    task automatic chk(input string req, input string sig, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, sig, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // position model from the requirements
    int  c_pix, c_line, p_pix, p_line;
    bit  c_mode, p_mode;
    int  c_shut, p_shut;
    bit  pv_valid;

    always @(posedge clk) begin
        if (rst) begin
            c_pix = 0; c_line = 1; c_mode = mode_fast; c_shut = int'(shutter_lines);
            pv_valid = 0;
        end else begin
            p_pix = c_pix; p_line = c_line; p_mode = c_mode; p_shut = c_shut;
            pv_valid = 1;
            if (c_pix == LC - 1) begin
                c_pix = 0;
                if (c_line == (c_mode ? FL : PL)) begin
                    c_line = 1; c_mode = mode_fast; c_shut = int'(shutter_lines);
                end else c_line++;
            end else c_pix++;
        end
    end

    function automatic logic [3:0] exp_v(int p, int ln, bit fast);
        int np = fast ? 4 : 1;
        if (ln != 1 && p >= VTS && p < VTS + 3 * VST * np) begin
            case (((p - VTS) / VST) % 3)
                0: return 4'b1100;
                1: return 4'b1001;
                default: return 4'b0011;
            endcase
        end
        return 4'b0110;
    endfunction

    always @(negedge clk) begin
        if (pv_valid && !rst && !done) begin
            bit gate, act, subx;
            int flen;
            flen = p_mode ? FL : PL;
            gate = (p_line == 1) && (p_pix >= SGS + SGG) && (p_pix < SGS + SGG + SGC);
            act  = (p_pix >= HACT);
            subx = (p_shut != 0) && (p_line >= 2) && (p_line + p_shut <= flen) &&
                   (p_pix >= SUBS) && (p_pix < SUBS + SUBC);
            chk("R2", "hd_n", 16'(hd_n), 16'(!(p_pix < HDC)));
            chk("R3", "vd_n", 16'(vd_n), 16'(p_line != 1));
            chk("R5", "vphase", 16'(vphase), 16'(exp_v(p_pix, p_line, p_mode)));
            chk("R6", "xsg1_n", 16'(xsg1_n), 16'(!gate));
            chk("R7", "xsg2_n", 16'(xsg2_n), 16'(!(gate && !p_mode)));
            chk("R8", "h1", 16'(h1), 16'(act ? ((p_pix % 2) == 0) : 1'b1));
            chk("R8", "h2", 16'(h2), 16'(act ? ((p_pix % 2) == 1) : 1'b0));
            chk("R9", "rg", 16'(rg), 16'(act && (p_pix % 2) == 1));
            chk("R10", "sub_n", 16'(sub_n), 16'(!subx));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit prev_vd;
        int cyc, sub_cnt;
        // R1 reset state
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "hd_n", 16'(hd_n), 16'd1);
        chk("R1", "vd_n", 16'(vd_n), 16'd1);
        chk("R1", "vphase", 16'(vphase), 16'h6);
        chk("R1", "xsg1_n", 16'(xsg1_n), 16'd1);
        chk("R1", "xsg2_n", 16'(xsg2_n), 16'd1);
        chk("R1", "h1", 16'(h1), 16'd1);
        chk("R1", "h2", 16'(h2), 16'd0);
        chk("R1", "rg", 16'(rg), 16'd0);
        chk("R1", "sub_n", 16'(sub_n), 16'd1);
        rst = 1'b0;
        // first cycle after release shows pixel 0 of line 1 (R1)
        @(negedge clk);
        chk("R1", "vd_n_first", 16'(vd_n), 16'd0);
        chk("R1", "hd_n_first", 16'(hd_n), 16'd0);

        // table walk, changes land mid-frame (R4 via the model)
        for (int i = 0; i < NSC; i++) begin
            mode_fast     = SCEN[i].mode;
            shutter_lines = SCEN[i].shut;
            repeat (int'(SCEN[i].cyc)) @(negedge clk);
        end

        // directed: frame length and substrate count, R3 R10 R11
        for (int k = 0; k < 2; k++) begin
            mode_fast     = (k == 1);
            shutter_lines = (k == 0) ? LW'(3) : LW'(0);
            prev_vd = vd_n;
            for (int w = 0; w < 2; w++) begin
                forever begin
                    @(negedge clk);
                    if (prev_vd && !vd_n) begin prev_vd = vd_n; break; end
                    prev_vd = vd_n;
                end
            end
            cyc = 0; sub_cnt = 0;
            forever begin
                if (!sub_n) sub_cnt++;
                cyc++;
                @(negedge clk);
                if (prev_vd && !vd_n) break;
                prev_vd = vd_n;
            end
            if (k == 0) begin
                chk("R3", "prog_frame_len", 16'(cyc), 16'(PL * LC));
                chk("R10", "sub_low_cycles", 16'(sub_cnt), 16'((PL - 3 - 1) * SUBC));
            end else begin
                chk("R3", "fast_frame_len", 16'(cyc), 16'(FL * LC));
                chk("R11", "sub_low_cycles", 16'(sub_cnt), 16'd0);
            end
        end
        done = 1;
        finish_run();
    end

endmodule